// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial slave (SMBus/I2C signalling) that gives a host access to a small bank of 8-bit control registers. The registers drive the rest of the chip through a flat parallel bus. A fast system clock oversamples the serial clock and data lines. The block finds START, repeated START and STOP conditions, matches its 7-bit address, and decodes a command byte. The command byte selects either single-register access at a given offset or a block access that always begins at offset 0.

The slave only ever pulls the data line low. It exposes a drive enable and a data output that is tied low. The register bank comes out of reset with fixed values. The highest register is a read-only identification byte. A block write carries a byte count ahead of its data. A block read returns the register count first and then the registers in ascending order. The host may end either kind of block transfer after any whole byte.

Top module: `smbreg_top`

## Requirements
- R1: Only the address 1101001 is acknowledged (D2h for write, D3h for read). After any other address the slave acknowledges nothing and drives nothing until the next START.
- R2: After reset the registers read FFh, FFh, D7h, 5Fh, 03h, 00h, 00h and 18h for offsets 0 to 7, and SDA is not driven.
- R3: A byte write has a command with bit 7 = 1 and bits 6:5 = 00. Command bits 4:0 give the offset, and the next data byte is stored at that offset, most significant bit first.
- R4: A byte read has an address+W, a byte command, a repeated START and then address D3h. The slave returns the register at the commanded offset, most significant bit first.
- R5: A command byte whose bits 6:5 are not 00 is not acknowledged and changes no register.
- R6: A block write has command bit 7 = 0, then a count byte, then data bytes stored from offset 0 upward. Only the counted bytes are stored. Further bytes are acknowledged and ignored.
- R7: A block read returns the register count (08h) first and then the registers from offset 0 upward, for as long as the host acknowledges.
- R8: When the host answers a read byte with NACK, the slave releases SDA and stays off the bus.
- R9: Writes to the identification register (offset 7) or to offsets above 7 are acknowledged but change nothing. Reads above offset 7 return 00h.
- R10: A START or STOP in the middle of a byte abandons the transfer. A partly received data byte is never stored, and a START restarts address matching.
- R11: For every accepted byte the slave pulls SDA low for exactly the ninth clock. It changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| sdaOut | output | 1 | Level driven when enabled, always 0 |
| regsOut | output | NUM_REGS*8 | All registers, offset 0 in the low byte |

## Verification
The synchronised SCL falling edge and an SDA change can arrive in the same system-clock cycle. The detector must treat that as an ordinary data change and not as a START or STOP. The bench provokes this with a tight timing mode: the master moves SDA on the same clock as it lowers SCL, and runs a byte write, a byte read and a partial block read in that mode. The slave's drive enable and all register outputs are compared with a behavioural bus model on every clock of each SCL-high phase. A false START or STOP would show up as a missing acknowledge, wrong read data or a register mismatch.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_CNT, K_DATA
  } byteKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              ptrLoad;
    logic [PTR_W-1:0]  ptrVal;
    logic              remLoad;
    logic [BYTE_W-1:0] remVal;
    logic              wrStb;
    logic              rdStb;
    logic [BYTE_W-1:0] wrData;
  } dpCtl_t;

  function automatic logic [BYTE_W-1:0] resetValue(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFF;
      2:       return 8'hD7;
      3:       return 8'h5F;
      4:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbreg_dp.sv
module smbreg_dp
  import smbreg_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter logic [7:0]  ID_VALUE = 8'h18
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtl_t                     ctl,
  output logic [BYTE_W-1:0]          rdData,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);

  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rem;
  logic              doWrite;

  assign doWrite = ctl.wrStb && (rem != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      rem <= '0;
    end else begin
      if (ctl.ptrLoad)              ptr <= ctl.ptrVal;
      else if (doWrite || ctl.rdStb) ptr <= ptr + 1'b1;
      if (ctl.remLoad)              rem <= ctl.remVal;
      else if (doWrite)             rem <= rem - 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gReg
    if (gi == NUM_REGS - 1) begin : gId
      assign regsOut[gi*BYTE_W +: BYTE_W] = ID_VALUE;
    end else begin : gRw
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                q <= resetValue(gi);
        else if (doWrite && ptr == PTR_W'(gi))    q <= ctl.wrData;
      end
      assign regsOut[gi*BYTE_W +: BYTE_W] = q;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == PTR_W'(i)) rdData = regsOut[i*BYTE_W +: BYTE_W];
  end

  // registers move only after a write strobe
  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regsOut) |-> $past(ctl.wrStb)); // R3
  // exhausted block count blocks further stores
  AST_COUNT_EXHAUSTED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrStb && rem == '0) |=> $stable(regsOut)); // R6
  // read-only and unmapped offsets never change
  AST_RO_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrStb && ptr >= PTR_W'(NUM_REGS - 1)) |=> $stable(regsOut)); // R9

endmodule

// File: rtl/smbreg_ctl.sv
module smbreg_ctl
  import smbreg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  output dpCtl_t            ctl,
  output logic              sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclP, sdaP;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startC, stopC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclSync[1];
      sdaP    <= sdaSync[1];
    end
  end

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startC  = sclS & sclP & sdaP & ~sdaS;
  assign stopC   = sclS & sclP & ~sdaP & sdaS;

  busState_t         state;
  byteKind_t         kind;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic              goTx, firstTx, blockMode, ackd;

  logic              rxDone, accept, txLoad;
  logic [BYTE_W-1:0] txByte;

  assign rxDone = (state == ST_RX) && sclFall && (bitCnt == 4'd8);
  assign txLoad = sclFall && (((state == ST_RXACK) && goTx) ||
                              ((state == ST_TXACK) && ackd));
  assign txByte = firstTx ? BYTE_W'(NUM_REGS) : rdData;

  always_comb begin
    case (kind)
      K_ADDR:  accept = (shReg[7:1] == DEV_ADDR);
      K_CMD:   accept = (shReg[6:5] == 2'b00);
      default: accept = 1'b1;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.wrData = shReg;
    if (rxDone && accept) begin
      case (kind)
        K_CMD: begin
          ctl.ptrLoad = 1'b1;
          ctl.ptrVal  = shReg[7] ? shReg[PTR_W-1:0] : '0;
          ctl.remLoad = 1'b1;
          ctl.remVal  = shReg[7] ? 8'd1 : 8'd0;
        end
        K_CNT: begin
          ctl.remLoad = 1'b1;
          ctl.remVal  = shReg;
        end
        K_DATA:  ctl.wrStb = 1'b1;
        default: ;
      endcase
    end
    ctl.rdStb = txLoad && !firstTx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      bitCnt    <= '0;
      shReg     <= '0;
      goTx      <= 1'b0;
      firstTx   <= 1'b0;
      blockMode <= 1'b0;
      ackd      <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (startC) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopC) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt != 4'd8) begin
            shReg  <= {shReg[6:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
          end else if (rxDone) begin
            if (accept) begin
              state <= ST_RXACK;
              sdaOe <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
            goTx    <= (kind == K_ADDR) && shReg[0];
            firstTx <= blockMode;
            case (kind)
              K_ADDR: kind <= K_CMD;
              K_CMD: begin
                kind <= shReg[7] ? K_DATA : K_CNT;
                if (accept) blockMode <= ~shReg[7];
              end
              K_CNT:   kind <= K_DATA;
              default: kind <= K_DATA;
            endcase
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (goTx) begin
              state   <= ST_TX;
              shReg   <= txByte;
              sdaOe   <= ~txByte[7];
              firstTx <= 1'b0;
            end else begin
              state <= ST_RX;
              sdaOe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state <= ST_TXACK;
              sdaOe <= 1'b0;
            end else begin
              shReg  <= {shReg[6:0], 1'b0};
              sdaOe  <= ~shReg[6];
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            ackd <= ~sdaS;
          end else if (sclFall) begin
            if (ackd) begin
              state   <= ST_TX;
              shReg   <= txByte;
              sdaOe   <= ~txByte[7];
              bitCnt  <= '0;
              firstTx <= 1'b0;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // an address acknowledge only follows a matching address
  AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && $past(state) == ST_RX && $past(kind) == K_ADDR)
      |-> $past(shReg[7:1]) == DEV_ADDR); // R1
  // STOP always frees the line
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopC |=> !sdaOe); // R10
  // drive changes only at SCL low edges or bus conditions
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall || startC || stopC)); // R11
  // host NACK leaves the line released
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TXACK && sclFall && !ackd) |=> !sdaOe); // R8

endmodule

// File: rtl/smbreg_top.sv
module smbreg_top
  import smbreg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] ID_VALUE = 8'h18
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic                       sdaOut,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);

  dpCtl_t            ctl;
  logic [BYTE_W-1:0] rdData;

  assign sdaOut = 1'b0;

  smbreg_ctl #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) uCtl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .ctl(ctl), .sdaOe(sdaOe)
  );

  smbreg_dp #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rdData(rdData), .regsOut(regsOut)
  );

endmodule

// File: tb/tb_smbreg_top.sv
`timescale 1ns/1ps
module tb_smbreg_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaBus;
  logic        sdaOe, sdaOut;
  logic [63:0] regsOut;

  int  checks = 0;
  int  errors = 0;
  bit  tight = 1'b0;
  logic [7:0] mReg [8];

  always #2.5 clk = ~clk;

  assign sdaBus = sdaM & ~sdaOe;

  smbreg_top dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .sdaOut(sdaOut), .regsOut(regsOut)
  );

  function automatic logic [63:0] expFlat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = mReg[i];
    return f;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one SCL period; compares the model on every clock of the high phase
  task automatic bitCycle(input logic b, input logic expOe, input string tag);
    if (!tight) waitClk(4);
    sdaM = b;
    waitClk(4);
    scl = 1'b1;
    repeat (8) begin
      @(negedge clk);
      check(sdaOe === expOe, tag, 64'(sdaOe), 64'(expOe));
      check(regsOut === expFlat(), tag, regsOut, expFlat());
    end
    @(posedge clk);
    #1;
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input logic expAck, input string tag,
                          input bit doW, input int idx);
    for (int i = 7; i >= 0; i--) bitCycle(v[i], 1'b0, tag);
    if (doW) mReg[idx] = v;
    bitCycle(1'b1, expAck, {tag, "/R11"});
  endtask

  task automatic readByte(input logic [7:0] exp, input bit hostAck, input string tag);
    for (int i = 7; i >= 0; i--) bitCycle(1'b1, ~exp[i], tag);
    bitCycle(hostAck ? 1'b0 : 1'b1, 1'b0, hostAck ? tag : "R8");
  endtask

  task automatic startCond();
    sdaM = 1'b1;
    waitClk(4);
    scl = 1'b1;
    waitClk(6);
    sdaM = 1'b0;
    waitClk(6);
    scl = 1'b0;
  endtask

  task automatic stopCond();
    sdaM = 1'b0;
    waitClk(4);
    scl = 1'b1;
    waitClk(6);
    sdaM = 1'b1;
    waitClk(6);
  endtask

  task automatic byteWrite(input logic [4:0] off, input logic [7:0] v,
                           input bit doW, input string tag);
    startCond();
    sendByte(8'hD2, 1'b1, tag, 1'b0, 0);
    sendByte({3'b100, off}, 1'b1, tag, 1'b0, 0);
    sendByte(v, 1'b1, tag, doW, int'(off));
    stopCond();
  endtask

  task automatic byteRead(input logic [4:0] off, input logic [7:0] exp, input string tag);
    startCond();
    sendByte(8'hD2, 1'b1, tag, 1'b0, 0);
    sendByte({3'b100, off}, 1'b1, tag, 1'b0, 0);
    startCond();
    sendByte(8'hD3, 1'b1, tag, 1'b0, 0);
    readByte(exp, 1'b0, tag);
    stopCond();
    check(sdaOe === 1'b0, "R8", 64'(sdaOe), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mReg[0] = 8'hFF; mReg[1] = 8'hFF; mReg[2] = 8'hD7; mReg[3] = 8'h5F;
    mReg[4] = 8'h03; mReg[5] = 8'h00; mReg[6] = 8'h00; mReg[7] = 8'h18;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R2: reset state
    check(regsOut === expFlat(), "R2", regsOut, expFlat());
    check(sdaOe === 1'b0, "R2", 64'(sdaOe), 64'd0);

    // R3 / R4: indexed write then read back
    byteWrite(5'd2, 8'h3C, 1'b1, "R3");
    byteRead(5'd2, mReg[2], "R4");

    // R1: foreign address, slave stays silent
    startCond();
    sendByte(8'hA4, 1'b0, "R1", 1'b0, 0);
    sendByte(8'h82, 1'b0, "R1", 1'b0, 0);
    sendByte(8'h99, 1'b0, "R1", 1'b0, 0);
    stopCond();

    // R5: chip-select field 01 rejected
    startCond();
    sendByte(8'hD2, 1'b1, "R5", 1'b0, 0);
    sendByte(8'hA2, 1'b0, "R5", 1'b0, 0);
    sendByte(8'h77, 1'b0, "R5", 1'b0, 0);
    stopCond();

    // R6: block write of three bytes, a fourth is ignored
    startCond();
    sendByte(8'hD2, 1'b1, "R6", 1'b0, 0);
    sendByte(8'h00, 1'b1, "R6", 1'b0, 0);
    sendByte(8'h03, 1'b1, "R6", 1'b0, 0);
    sendByte(8'h11, 1'b1, "R6", 1'b1, 0);
    sendByte(8'h22, 1'b1, "R6", 1'b1, 1);
    sendByte(8'h33, 1'b1, "R6", 1'b1, 2);
    sendByte(8'h44, 1'b1, "R6", 1'b0, 0);
    stopCond();
    check(regsOut[31:24] === 8'h5F, "R6", 64'(regsOut[31:24]), 64'h5F);

    // R7: block read of count plus all registers
    startCond();
    sendByte(8'hD2, 1'b1, "R7", 1'b0, 0);
    sendByte(8'h00, 1'b1, "R7", 1'b0, 0);
    startCond();
    sendByte(8'hD3, 1'b1, "R7", 1'b0, 0);
    readByte(8'h08, 1'b1, "R7");
    for (int i = 0; i < 8; i++) readByte(mReg[i], i != 7, "R7");
    stopCond();
    check(sdaOe === 1'b0, "R8", 64'(sdaOe), 64'd0);

    // R9: read-only and unmapped offsets
    byteWrite(5'd7, 8'h55, 1'b0, "R9");
    byteWrite(5'd9, 8'h66, 1'b0, "R9");
    byteRead(5'd12, 8'h00, "R9");
    byteRead(5'd7, 8'h18, "R9");

    // R10: STOP inside a data byte
    startCond();
    sendByte(8'hD2, 1'b1, "R10", 1'b0, 0);
    sendByte(8'h84, 1'b1, "R10", 1'b0, 0);
    for (int i = 0; i < 4; i++) bitCycle(1'b0, 1'b0, "R10");
    stopCond();
    check(regsOut[39:32] === mReg[4], "R10", 64'(regsOut[39:32]), 64'(mReg[4]));
    // R10: START inside a data byte restarts addressing
    startCond();
    sendByte(8'hD2, 1'b1, "R10", 1'b0, 0);
    sendByte(8'h85, 1'b1, "R10", 1'b0, 0);
    for (int i = 0; i < 3; i++) bitCycle(1'b1, 1'b0, "R10");
    startCond();
    sendByte(8'hD2, 1'b1, "R10", 1'b0, 0);
    sendByte(8'h85, 1'b1, "R10", 1'b0, 0);
    sendByte(8'h5A, 1'b1, "R10", 1'b1, 5);
    stopCond();
    check(regsOut[47:40] === 8'h5A, "R10", 64'(regsOut[47:40]), 64'h5A);

    // SDA moved on the same clock as SCL falls
    tight = 1'b1;
    byteWrite(5'd3, 8'hA5, 1'b1, "R3");
    byteRead(5'd3, 8'hA5, "R4");
    startCond();
    sendByte(8'hD2, 1'b1, "R7", 1'b0, 0);
    sendByte(8'h00, 1'b1, "R7", 1'b0, 0);
    startCond();
    sendByte(8'hD3, 1'b1, "R7", 1'b0, 0);
    readByte(8'h08, 1'b1, "R7");
    readByte(mReg[0], 1'b1, "R7");
    readByte(mReg[1], 1'b0, "R7");
    stopCond();
    tight = 1'b0;
    check(regsOut === expFlat(), "R11", regsOut, expFlat());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule